// File: doc/BRIEF.md
# EPP Write Cycle Controller

This block sits between an ISA-style host I/O bus and a parallel port running the EPP 1.7 write protocol. A single host I/O write, with its strobe low, becomes one peripheral handshake. A write to port 0 sends a data byte under the data strobe. A write to port 1 sends an address byte under the address strobe. The block drives the direction line, the port data and the chosen strobe in a fixed order. It holds the host in wait states through its ready output until the peripheral acknowledges by raising its wait line. If the peripheral never answers, a hardware window of about 10 to 12 µs ends the stall and sets a sticky status flag. A host write of 1 to port 2 clears that flag.

All host inputs are taken as synchronous to `clk`. The peripheral's `nwait_i` passes through a two-stage synchronizer before the sequencer uses it. The host bus has no valid/ready pair. The back-pressure rule is that `host_rdy` low means the host must keep its strobe and data steady. `host_rdy` falls in the same cycle a transfer write is presented, and it stays low until the peripheral acknowledges or the window expires. A write that arrives while a cycle is still finishing sees `host_rdy` low until the block is idle again. The sequencer then takes that write.

Top module: `epp_wr_engine`

## Requirements
- R1: While reset is held and after it is released, `host_rdy`=1, `nwrite_o`=1, `ndatastb_o`=1, `naddrstb_o`=1, `pd_oe`=0 and `tmo_flag`=0.
- R2: A write starts a peripheral cycle only when `port_dir`=0 and `host_addr` is 0 or 1. A write with `port_dir`=1, or to address 3, leaves all peripheral outputs idle and `host_rdy` high.
- R3: One clock after a transfer write is taken, `nwrite_o` is low, `pd_oe` is 1 and `pd_o` carries the host data. The strobe asserts one clock after that.
- R4: Address 0 drives `ndatastb_o` low and address 1 drives `naddrstb_o` low. The two strobes are never low together.
- R5: `host_rdy` is low from the cycle a transfer write is presented until the synchronized `nwait_i` is seen high during the strobe phase. If `nwait_i` rises at clock edge n, `host_rdy` returns high after edge n+3.
- R6: The strobe stays low until the host releases `host_wr_n`, and it goes high one clock after that. `pd_o` holds its value for the whole time the strobe is low, and for one clock after it rises.
- R7: `nwrite_o` changes only when both strobes were high in the previous cycle. `pd_oe` drops together with the return of `nwrite_o` high.
- R8: If acknowledge has not been seen after TMO_CYC = CLK_MHZ*TMO_NS/1000 clocks in the strobe phase, `host_rdy` goes high and `tmo_flag` is set.
- R9: `tmo_flag` is sticky. A host write to address 2 with data bit 0 = 1 clears it. The same write with bit 0 = 0 leaves it set.
- R10: A write presented while a cycle is still in progress sees `host_rdy` low until the block is idle. It is then taken as a new cycle.
- R11: If acknowledge is seen on the same edge as expiry, the cycle ends normally and `tmo_flag` stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Host port select: 0 data, 1 address, 2 status |
| host_data | input | 8 | Host write data |
| host_wr_n | input | 1 | Host write strobe, active low |
| port_dir | input | 1 | Port direction, 0 = output |
| host_rdy | output | 1 | Host ready; low stretches the host cycle |
| tmo_flag | output | 1 | Sticky timeout status |
| pd_o | output | 8 | Peripheral data out |
| pd_oe | output | 1 | Peripheral data drive enable |
| nwrite_o | output | 1 | Write direction line, low during a cycle |
| ndatastb_o | output | 1 | Data strobe, active low |
| naddrstb_o | output | 1 | Address strobe, active low |
| nwait_i | input | 1 | Peripheral wait/acknowledge, asynchronous |

## Verification
The bench builds the block with CLK_MHZ=1 and TMO_NS=8000, which gives an 8-clock timeout window. With that window, one sweep of the acknowledge delay from "already high" through "never" covers every outcome. It crosses normal completion, the tie where acknowledge and expiry land on the same edge, and every timeout case. Each outcome is run for both the data port and the address port. The short window also lets the bench follow every timeout with the status-clear writes, and run the held-off back-to-back write, within a short run.

// File: rtl/epp_wr_pkg.sv
package epp_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_STB   = 3'd2,
    ST_WREL  = 3'd3,
    ST_HOLD  = 3'd4
  } epp_state_e;

  localparam logic [1:0] PORT_DATA = 2'd0;
  localparam logic [1:0] PORT_ADDR = 2'd1;
  localparam logic [1:0] PORT_STAT = 2'd2;
endpackage

// File: rtl/epp_wr_sync.sv
module epp_wr_sync #(
  parameter int  STAGES = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/epp_wr_timer.sv
module epp_wr_timer #(
  parameter int LIMIT = 550
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run_i)         cnt <= '0;
    else if (cnt != LAST)    cnt <= cnt + 1'b1;
  end

  assign expire_o = run_i && (cnt == LAST);
endmodule

// File: rtl/epp_wr_seq.sv
module epp_wr_seq
  import epp_wr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_data,
  input  logic          host_wr_n,
  input  logic          port_dir,
  input  logic          ack_i,
  input  logic          expire_i,
  output logic          run_o,
  output logic          host_rdy,
  output logic          tmo_flag,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe,
  output logic          nwrite_o,
  output logic          ndatastb_o,
  output logic          naddrstb_o
);
  epp_state_e    state, nxt;
  logic          armed;
  logic          tgt_addr, tgt_nxt;
  logic [DW-1:0] data_q;
  logic          new_wr, xfer_req, start, clr_req;
  logic          stb_phase;

  assign new_wr   = armed && !host_wr_n;
  assign xfer_req = !port_dir && !host_addr[1];
  assign start    = (state == ST_IDLE) && new_wr && xfer_req;
  assign clr_req  = (state == ST_IDLE) && new_wr && (host_addr == PORT_STAT) && host_data[0];

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_SETUP;
      ST_SETUP: nxt = ST_STB;
      ST_STB:   if (ack_i || expire_i) nxt = ST_WREL;
      ST_WREL:  if (host_wr_n) nxt = ST_HOLD;
      ST_HOLD:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign tgt_nxt   = start ? host_addr[0] : tgt_addr;
  assign stb_phase = (nxt == ST_STB) || (nxt == ST_WREL);
  assign run_o     = (state == ST_STB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      tgt_addr   <= 1'b0;
      data_q     <= '0;
      tmo_flag   <= 1'b0;
      nwrite_o   <= 1'b1;
      pd_oe      <= 1'b0;
      ndatastb_o <= 1'b1;
      naddrstb_o <= 1'b1;
    end else begin
      state    <= nxt;
      tgt_addr <= tgt_nxt;
      if (host_wr_n)                       armed <= 1'b1;
      else if (state == ST_IDLE && armed)  armed <= 1'b0;
      if (start) data_q <= host_data;
      if (state == ST_STB && expire_i && !ack_i) tmo_flag <= 1'b1;
      else if (clr_req)                          tmo_flag <= 1'b0;
      nwrite_o   <= (nxt == ST_IDLE);
      pd_oe      <= (nxt != ST_IDLE);
      ndatastb_o <= !(stb_phase && !tgt_nxt);
      naddrstb_o <= !(stb_phase &&  tgt_nxt);
    end
  end

  assign pd_o = data_q;

  always_comb begin
    host_rdy = 1'b1;
    if (state == ST_SETUP || state == ST_STB) host_rdy = 1'b0;
    if (new_wr && ((state != ST_IDLE) || xfer_req)) host_rdy = 1'b0;
  end
endmodule

// File: rtl/epp_wr_engine.sv
module epp_wr_engine #(
  parameter int CLK_MHZ = 50,
  parameter int TMO_NS  = 11000,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_data,
  input  logic          host_wr_n,
  input  logic          port_dir,
  output logic          host_rdy,
  output logic          tmo_flag,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe,
  output logic          nwrite_o,
  output logic          ndatastb_o,
  output logic          naddrstb_o,
  input  logic          nwait_i
);
  localparam int TMO_CYC = (CLK_MHZ * TMO_NS) / 1000;

  logic ack_s, expire, run;

  epp_wr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(nwait_i), .q_o(ack_s)
  );

  epp_wr_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run), .expire_o(expire)
  );

  epp_wr_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_data(host_data), .host_wr_n(host_wr_n),
    .port_dir(port_dir), .ack_i(ack_s), .expire_i(expire), .run_o(run),
    .host_rdy(host_rdy), .tmo_flag(tmo_flag), .pd_o(pd_o), .pd_oe(pd_oe),
    .nwrite_o(nwrite_o), .ndatastb_o(ndatastb_o), .naddrstb_o(naddrstb_o)
  );
endmodule

// File: rtl/epp_wr_chk.sv
module epp_wr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    host_addr,
  input logic          host_wr_n,
  input logic          port_dir,
  input logic          host_rdy,
  input logic          tmo_flag,
  input logic [DW-1:0] pd_o,
  input logic          nwrite_o,
  input logic          ndatastb_o,
  input logic          naddrstb_o
);
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ndatastb_o && !naddrstb_o));

  assert_nwrite_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nwrite_o != $past(nwrite_o)) |-> ($past(ndatastb_o) && $past(naddrstb_o)));

  assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ndatastb_o) || $fell(naddrstb_o)) |-> $past(!nwrite_o));

  assert_release_after_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ndatastb_o) || $rose(naddrstb_o)) |-> $past(host_wr_n));

  assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ndatastb_o && naddrstb_o) && $past(!(ndatastb_o && naddrstb_o))) |-> $stable(pd_o));

  assert_dir_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nwrite_o) |-> $past(!port_dir && !host_addr[1] && !host_wr_n));

  assert_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ndatastb_o) || $fell(naddrstb_o)) |-> !host_rdy);

  assert_flag_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(!host_rdy));
endmodule

bind epp_wr_engine epp_wr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_n(host_wr_n),
  .port_dir(port_dir), .host_rdy(host_rdy), .tmo_flag(tmo_flag), .pd_o(pd_o),
  .nwrite_o(nwrite_o), .ndatastb_o(ndatastb_o), .naddrstb_o(naddrstb_o)
);

// File: tb/sim_epp_wr_engine.sv
module sim_epp_wr_engine;
  localparam int CLK_MHZ = 1;
  localparam int TMO_NS  = 8000;
  localparam int L       = (CLK_MHZ * TMO_NS) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_data = 8'd0;
  logic       host_wr_n = 1'b1;
  logic       port_dir = 1'b0;
  logic       nwait_i = 1'b0;
  logic       host_rdy, tmo_flag, pd_oe, nwrite_o, ndatastb_o, naddrstb_o;
  logic [7:0] pd_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  epp_wr_engine #(.CLK_MHZ(CLK_MHZ), .TMO_NS(TMO_NS), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_data(host_data),
    .host_wr_n(host_wr_n), .port_dir(port_dir), .host_rdy(host_rdy),
    .tmo_flag(tmo_flag), .pd_o(pd_o), .pd_oe(pd_oe), .nwrite_o(nwrite_o),
    .ndatastb_o(ndatastb_o), .naddrstb_o(naddrstb_o), .nwait_i(nwait_i)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk({req, " rdy"}, host_rdy, 1);
    chk({req, " nwrite"}, nwrite_o, 1);
    chk({req, " dstb"}, ndatastb_o, 1);
    chk({req, " astb"}, naddrstb_o, 1);
    chk({req, " oe"}, pd_oe, 0);
  endtask

  // dly: -1 = acknowledge already high, 99 = never; otherwise nwait rises at negedge 2+dly
  task automatic xfer(input int a, input logic [7:0] d, input int dly);
    int rise;
    int exp_rise;
    rise = -1;
    if (dly < 0) begin
      nwait_i = 1'b1;
      repeat (3) @(negedge clk);
    end
    exp_rise = (dly < 0) ? 3 : (((5 + dly) < (2 + L)) ? (5 + dly) : (2 + L));
    @(negedge clk);
    host_addr = 2'(a); host_data = d; host_wr_n = 1'b0;
    #1 chk("R5 rdy low on entry", host_rdy, 0);
    @(negedge clk);
    chk("R3 nwrite setup", nwrite_o, 0);
    chk("R3 oe setup", pd_oe, 1);
    chk("R3 data setup", pd_o, d);
    chk("R3 no strobe in setup", ndatastb_o & naddrstb_o, 1);
    for (int k = 2; k <= 40; k++) begin
      @(negedge clk);
      if (k == 2) begin
        chk("R4 data strobe", ndatastb_o, (a == 1) ? 1 : 0);
        chk("R4 addr strobe", naddrstb_o, (a == 0) ? 1 : 0);
      end
      if (host_rdy) begin rise = k; break; end
      if (k == 2 + dly) nwait_i = 1'b1;
    end
    chk("R5 R8 rdy return cycle", rise, exp_rise);
    if (dly == L - 3) chk("R11 tie is normal", tmo_flag, 0);
    else              chk("R8 flag", tmo_flag, (dly > L - 3) ? 1 : 0);
    chk("R6 strobe held", ndatastb_o & naddrstb_o, 0);
    repeat (2) @(negedge clk);
    chk("R6 strobe still held", ndatastb_o & naddrstb_o, 0);
    host_wr_n = 1'b1;
    @(negedge clk);
    chk("R6 strobe released", ndatastb_o & naddrstb_o, 1);
    chk("R6 data hold", pd_o, d);
    chk("R7 nwrite after release", nwrite_o, 0);
    @(negedge clk);
    chk("R7 nwrite returns", nwrite_o, 1);
    chk("R7 oe off", pd_oe, 0);
    nwait_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic stat_wr(input logic [7:0] d);
    @(negedge clk);
    host_addr = 2'd2; host_data = d; host_wr_n = 1'b0;
    #1 chk("R9 status write not stalled", host_rdy, 1);
    @(negedge clk);
    host_wr_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_outputs("R1 in reset");
    chk("R1 flag in reset", tmo_flag, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_outputs("R1 after reset");

    // R2: direction bit set, and unmapped address
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      port_dir  = (c != 2);
      host_addr = (c == 2) ? 2'd3 : 2'(c);
      host_data = 8'hA5; host_wr_n = 1'b0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        idle_outputs("R2 ignored write");
      end
      host_wr_n = 1'b1; port_dir = 1'b0;
      @(negedge clk);
    end

    // sweep of port and acknowledge delay
    for (int a = 0; a < 2; a++) begin
      for (int dly = -1; dly <= L + 2; dly++) begin
        xfer(a, 8'((a * 37 + dly * 13 + 5) & 255), (dly == L + 2) ? 99 : dly);
        if (tmo_flag) begin
          stat_wr(8'hFE);
          chk("R9 bit0 zero keeps flag", tmo_flag, 1);
          stat_wr(8'h01);
          chk("R9 clear", tmo_flag, 0);
        end
      end
    end

    // R10: back-to-back write held off during hold phase
    nwait_i = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk);
    host_addr = 2'd0; host_data = 8'h3C; host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 first done", host_rdy, 1);
    host_wr_n = 1'b1;
    @(negedge clk);
    host_addr = 2'd1; host_data = 8'hC3; host_wr_n = 1'b0;
    #1 chk("R10 held in hold", host_rdy, 0);
    @(negedge clk);
    chk("R10 held at idle", host_rdy, 0);
    chk("R10 idle nwrite", nwrite_o, 1);
    @(negedge clk);
    chk("R10 second setup", nwrite_o, 0);
    chk("R10 second data", pd_o, 8'hC3);
    @(negedge clk);
    chk("R10 second strobe", naddrstb_o, 0);
    @(negedge clk);
    chk("R10 second done", host_rdy, 1);
    host_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_outputs("R10 end");
    nwait_i = 1'b0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule